// File: doc/BRIEF.md
# Badline Bus-Stall Arbiter

This block models, cycle by cycle, how a raster video controller takes the shared memory bus away from the processor on lines that need a character-pointer fetch. It keeps a position counter within the line and a line counter. It holds a small vertical-scroll register that the processor writes. A comparator declares a line "bad" when the display is enabled, the line lies inside the display window, and the line's low three bits equal the scroll value.

On a bad line the bus-available output falls first as a warning. Three cycles later the address-enable output falls and the controller owns the bus for the fetch. The fetch window always closes at the same cycle. A trigger that arrives late therefore shortens the fetch and hands the lost cycles back to the processor. During the warning cycles the processor may still finish write cycles. Its first read halts it until the bus is returned. The fetch strobe and column index show which of the forty columns are fetched.

Top module: `badline_bus_arbiter`

## Requirements
- R1: The cycle counter runs 0 to 62 and wraps to 0. The line counter advances on that wrap and returns to 0 after line 311.
- R2: A line is bad when scroll bit 3 (display enable) is 1, the line lies in 0x30..0xF7 inclusive, and line bits [2:0] equal scroll bits [2:0]. A register write takes effect in the cycle after the write strobe.
- R3: On a bad line, `ba` goes low in the first cycle within 12..54 where the condition holds. It stays low through cycle 54 even if the register changes, and is high again at cycle 55.
- R4: `aec` goes low exactly three cycles after `ba` fell and never before cycle 15. It stays low through cycle 54.
- R5: `dma_fetch` is high exactly in the cycles where `aec` is low, with `dma_col` equal to the cycle number minus 15.
- R6: While `ba` is high, `cpu_rdy` is high. While `aec` is low, `cpu_rdy` is low. In the warning cycles a write (`cpu_rd`=0) proceeds. The first read halts the processor until `ba` rises, and `cpu_rdy` is high again at cycle 55.
- R7: When the bad condition first holds at cycle 12+k (0≤k≤42), `ba` is low for 43−k cycles. min(3, 43−k) of these are warning cycles and the rest are fetches, so a full line fetches 40 columns. With reads throughout, 43−k cycles are stalled.
- R8: Lines outside the window, lines with display enable clear, and lines whose bits do not match leave `ba`, `aec` and `cpu_rdy` high and fetch nothing.
- R9: While `rst` is high, both counters read 0, `ba`, `aec` and `cpu_rdy` are high, and `dma_fetch` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the scroll register |
| reg_wdata | input | 4 | Bit 3 display enable, bits 2:0 fine vertical scroll |
| cpu_rd | input | 1 | Processor cycle type: 1 read, 0 write |
| ba | output | 1 | Bus available, low during warning and fetch |
| aec | output | 1 | Address enable, low while the controller owns the bus |
| cpu_rdy | output | 1 | Processor may complete its current cycle |
| dma_fetch | output | 1 | A pointer fetch happens in this cycle |
| dma_col | output | 6 | Column fetched, 0..39 |
| raster_cycle | output | 6 | Cycle within the line |
| raster_line | output | 9 | Current raster line |

## Verification
The sharpest overlap is a processor cycle landing in the same cycle that `ba` falls. A write there must pass, and a read there must halt at once. The bench provokes this by writing the matching scroll value one cycle before a chosen trigger cycle, while setting `cpu_rd` per cycle for a given number of leading write cycles. It judges the result by the totals of low `ba`, stalled and fetched cycles on that line, and by the first fetched column. A second overlap is a trigger so late that the warning runs into the fixed end of the fetch window. Triggers at cycles 52 and 53 must give a warning with no fetch at all.

// File: rtl/bl_arb_pkg.sv
`timescale 1ns/1ps
package bl_arb_pkg;

    // Scroll register layout: enable on top, fine scroll below.
    typedef struct packed {
        logic       disp_en;
        logic [2:0] fine_y;
    } vscroll_t;

    localparam int VSCROLL_W = $bits(vscroll_t);

    // Who holds the bus in the current cycle.
    typedef enum logic [1:0] {
        BUS_CPU  = 2'd0,
        BUS_WARN = 2'd1,
        BUS_DMA  = 2'd2
    } bus_phase_e;

    function automatic logic in_span(int unsigned v, int unsigned lo, int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/bl_raster_timer.sv
`timescale 1ns/1ps
module bl_raster_timer #(
    parameter int LINE_CYCLES = 63,
    parameter int NUM_LINES   = 312,
    parameter int CW          = 6,
    parameter int LW          = 9
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cyc,
    output logic [LW-1:0] line
);
    localparam logic [CW-1:0] CYC_LAST  = CW'(LINE_CYCLES - 1);
    localparam logic [LW-1:0] LINE_LAST = LW'(NUM_LINES - 1);

    logic wrap;
    assign wrap = (cyc == CYC_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc  <= '0;
            line <= '0;
        end else begin
            cyc <= wrap ? '0 : cyc + CW'(1);
            if (wrap) begin
                line <= (line == LINE_LAST) ? '0 : line + LW'(1);
            end
        end
    end
endmodule

// File: rtl/bl_scroll_reg.sv
`timescale 1ns/1ps
module bl_scroll_reg
    import bl_arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [VSCROLL_W-1:0] wdata,
    output vscroll_t             vs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vs <= '0;
        end else if (we) begin
            vs <= vscroll_t'(wdata);
        end
    end
endmodule

// File: rtl/bl_badline_detect.sv
`timescale 1ns/1ps
module bl_badline_detect
    import bl_arb_pkg::*;
#(
    parameter int LW        = 9,
    parameter int WIN_FIRST = 48,
    parameter int WIN_LAST  = 247
) (
    input  logic [LW-1:0] line,
    input  vscroll_t      vs,
    output logic          badline
);
    logic in_window;
    logic phase_hit;

    always_comb begin
        in_window = in_span(int'(line), WIN_FIRST, WIN_LAST);
        phase_hit = (line[2:0] == vs.fine_y);
        badline   = vs.disp_en && in_window && phase_hit;
    end
endmodule

// File: rtl/bl_bus_arbiter.sv
`timescale 1ns/1ps
module bl_bus_arbiter
    import bl_arb_pkg::*;
#(
    parameter int CW          = 6,
    parameter int COLW        = 6,
    parameter int FETCH_FIRST = 15,
    parameter int FETCH_LAST  = 54,
    parameter int WARN_CYCLES = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   cyc,
    input  logic            badline,
    input  logic            cpu_rd,
    output logic            ba,
    output logic            aec,
    output logic            cpu_rdy,
    output logic            dma_fetch,
    output logic [COLW-1:0] dma_col
);
    localparam int              WARN_FIRST = FETCH_FIRST - WARN_CYCLES;
    localparam int              WW         = $clog2(WARN_CYCLES + 1);
    localparam logic [WW-1:0]   WARN_DONE  = WW'(WARN_CYCLES);
    localparam logic [CW-1:0]   END_CYC    = CW'(FETCH_LAST);
    localparam logic [CW-1:0]   START_CYC  = CW'(FETCH_FIRST);

    logic          in_win;
    logic          ba_low;
    logic          hold_q;
    logic [WW-1:0] warn_q;
    logic          stall_q;
    logic          want_stall;
    bus_phase_e    phase;

    always_comb begin
        in_win     = in_span(int'(cyc), WARN_FIRST, FETCH_LAST);
        ba_low     = in_win && (badline || hold_q);
        if (ba_low && (warn_q == WARN_DONE) && (cyc >= START_CYC)) begin
            phase = BUS_DMA;
        end else if (ba_low) begin
            phase = BUS_WARN;
        end else begin
            phase = BUS_CPU;
        end
        want_stall = (phase != BUS_CPU) && (cpu_rd || stall_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= 1'b0;
            warn_q  <= '0;
            stall_q <= 1'b0;
        end else begin
            // Once the warning has begun it runs to the fixed end cycle.
            if (cyc == END_CYC) begin
                hold_q <= 1'b0;
            end else if (ba_low) begin
                hold_q <= 1'b1;
            end
            if (!ba_low) begin
                warn_q <= '0;
            end else if (warn_q != WARN_DONE) begin
                warn_q <= warn_q + WW'(1);
            end
            stall_q <= want_stall;
        end
    end

    always_comb begin
        ba        = (phase == BUS_CPU);
        aec       = (phase != BUS_DMA);
        dma_fetch = (phase == BUS_DMA);
        cpu_rdy   = !((phase == BUS_DMA) || want_stall);
        dma_col   = dma_fetch ? COLW'(cyc - START_CYC) : '0;
    end
endmodule

// File: rtl/badline_bus_arbiter.sv
`timescale 1ns/1ps
module badline_bus_arbiter
    import bl_arb_pkg::*;
#(
    parameter int LINE_CYCLES = 63,
    parameter int NUM_LINES   = 312,
    parameter int WIN_FIRST   = 48,
    parameter int WIN_LAST    = 247,
    parameter int FETCH_FIRST = 15,
    parameter int FETCH_COLS  = 40,
    parameter int WARN_CYCLES = 3,
    localparam int CW         = $clog2(LINE_CYCLES),
    localparam int LW         = $clog2(NUM_LINES),
    localparam int COLW       = $clog2(FETCH_COLS),
    localparam int FETCH_LAST = FETCH_FIRST + FETCH_COLS - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [VSCROLL_W-1:0] reg_wdata,
    input  logic                 cpu_rd,
    output logic                 ba,
    output logic                 aec,
    output logic                 cpu_rdy,
    output logic                 dma_fetch,
    output logic [COLW-1:0]      dma_col,
    output logic [CW-1:0]        raster_cycle,
    output logic [LW-1:0]        raster_line
);
    vscroll_t vs;
    logic     badline;

    bl_raster_timer #(
        .LINE_CYCLES(LINE_CYCLES), .NUM_LINES(NUM_LINES), .CW(CW), .LW(LW)
    ) u_timer (
        .clk(clk), .rst(rst), .cyc(raster_cycle), .line(raster_line)
    );

    bl_scroll_reg u_scroll (
        .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .vs(vs)
    );

    bl_badline_detect #(
        .LW(LW), .WIN_FIRST(WIN_FIRST), .WIN_LAST(WIN_LAST)
    ) u_detect (
        .line(raster_line), .vs(vs), .badline(badline)
    );

    bl_bus_arbiter #(
        .CW(CW), .COLW(COLW), .FETCH_FIRST(FETCH_FIRST),
        .FETCH_LAST(FETCH_LAST), .WARN_CYCLES(WARN_CYCLES)
    ) u_arb (
        .clk(clk), .rst(rst), .cyc(raster_cycle), .badline(badline),
        .cpu_rd(cpu_rd), .ba(ba), .aec(aec), .cpu_rdy(cpu_rdy),
        .dma_fetch(dma_fetch), .dma_col(dma_col)
    );
endmodule

// File: rtl/badline_bus_arbiter_chk.sv
`timescale 1ns/1ps
module badline_bus_arbiter_chk #(
    parameter int CW          = 6,
    parameter int COLW        = 6,
    parameter int FETCH_FIRST = 15,
    parameter int FETCH_LAST  = 54,
    parameter int WARN_CYCLES = 3,
    parameter int LINE_LAST   = 62
) (
    input logic            clk,
    input logic            rst,
    input logic            cpu_rd,
    input logic            ba,
    input logic            aec,
    input logic            cpu_rdy,
    input logic            dma_fetch,
    input logic [COLW-1:0] dma_col,
    input logic [CW-1:0]   raster_cycle
);
    // Cycles that ba has already been low before the current one.
    logic [7:0] low_cnt;
    always_ff @(posedge clk) begin
        if (rst || ba) begin
            low_cnt <= '0;
        end else if (low_cnt != 8'hFF) begin
            low_cnt <= low_cnt + 8'd1;
        end
    end

    p_cycle_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (raster_cycle == CW'(LINE_LAST)) |=> (raster_cycle == '0));

    p_ba_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ba && (raster_cycle != CW'(FETCH_LAST))) |=> !ba);

    p_bus_release_r3: assert property (@(posedge clk) disable iff (rst)
        (raster_cycle == CW'(FETCH_LAST + 1)) |-> (ba && aec));

    p_aec_after_warn_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(aec) |-> (low_cnt == 8'(WARN_CYCLES)));

    p_aec_needs_ba_r4: assert property (@(posedge clk) disable iff (rst)
        !aec |-> (!ba && (low_cnt >= 8'(WARN_CYCLES))));

    p_fetch_col_r5: assert property (@(posedge clk) disable iff (rst)
        dma_fetch |-> (!aec && (raster_cycle >= CW'(FETCH_FIRST))
                       && (raster_cycle <= CW'(FETCH_LAST))
                       && (CW'(dma_col) == raster_cycle - CW'(FETCH_FIRST))));

    p_rdy_when_ba_r6: assert property (@(posedge clk) disable iff (rst)
        ba |-> cpu_rdy);

    p_rdy_off_in_dma_r6: assert property (@(posedge clk) disable iff (rst)
        !aec |-> !cpu_rdy);

    p_first_write_passes_r6: assert property (@(posedge clk) disable iff (rst)
        (!ba && aec && !cpu_rd && (low_cnt == 8'd0)) |-> cpu_rdy);
endmodule

bind badline_bus_arbiter badline_bus_arbiter_chk #(
    .CW(CW), .COLW(COLW), .FETCH_FIRST(FETCH_FIRST), .FETCH_LAST(FETCH_LAST),
    .WARN_CYCLES(WARN_CYCLES), .LINE_LAST(LINE_CYCLES - 1)
) u_chk (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .ba(ba), .aec(aec),
    .cpu_rdy(cpu_rdy), .dma_fetch(dma_fetch), .dma_col(dma_col),
    .raster_cycle(raster_cycle)
);

// File: tb/badline_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module badline_bus_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic       cpu_rd = 1'b1;
    logic       ba, aec, cpu_rdy, dma_fetch;
    logic [5:0] dma_col, raster_cycle;
    logic [8:0] raster_line;

    int  n_cmp  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    badline_bus_arbiter dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .cpu_rd(cpu_rd), .ba(ba), .aec(aec), .cpu_rdy(cpu_rdy),
        .dma_fetch(dma_fetch), .dma_col(dma_col),
        .raster_cycle(raster_cycle), .raster_line(raster_line)
    );

    // line, trigger cycle, leading write cycles, enable,
    // expected ba-low cycles, stalled cycles, fetches, first column (-1 none)
    typedef struct packed {
        int line; int trig; int nw; int den;
        int ba_n; int stall; int fetch; int col0;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{'h2F,  5,  0, 1,  0,  0,  0, -1},   // R8 above window
        '{'h30,  5,  0, 1, 43, 43, 40,  0},   // R7 full, reads
        '{'h33,  5,  3, 1, 43, 40, 40,  0},   // R6 writes in warning
        '{'h36,  5, 63, 1, 43, 40, 40,  0},   // R6 writes only
        '{'h39, 20,  0, 1, 35, 35, 32,  8},   // R7 late k=8
        '{'h3C, 30,  1, 1, 25, 24, 22, 18},   // R6 one write then read
        '{'h40, 53,  0, 1,  2,  2,  0, -1},   // R3 warning, no fetch
        '{'h45,  5,  0, 0,  0,  0,  0, -1},   // R8 display disabled
        '{'h48, 52,  3, 1,  3,  0,  0, -1},   // R6 writes only warning
        '{'h50, 12,  0, 1, 43, 43, 40,  0},   // R2 trigger exactly at 12
        '{'h58, 13,  0, 1, 42, 42, 39,  1},   // R7 k=1
        '{'hF7,  5,  0, 1, 43, 43, 40,  0},   // R2 last window line
        '{'hF8,  5,  0, 1,  0,  0,  0, -1}    // R8 below window
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (line %0h)", req, act, exp, raster_line);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int s = (v.trig < 12) ? 12 : v.trig;
        int ba_n = 0, st = 0, fc = 0, col0 = -1, colerr = 0;
        int first_ba = -1, last_ba = -1, first_aec = -1, last_aec = -1;
        int rel55 = 0;
        int c;
        do @(negedge clk);
        while (!(int'(raster_line) == v.line && int'(raster_cycle) == v.trig - 1));
        forever begin
            c = int'(raster_cycle);
            reg_we    = (c == v.trig - 1);
            reg_wdata = {v.den[0], 3'(v.line)};
            cpu_rd    = !(c >= s && c < s + v.nw);
            #1;
            if (c >= v.trig) begin
                if (!ba) begin
                    ba_n++;
                    if (first_ba < 0) first_ba = c;
                    last_ba = c;
                end
                if (!cpu_rdy) st++;
                if (dma_fetch) begin
                    fc++;
                    if (first_aec < 0) begin
                        first_aec = c;
                        col0 = int'(dma_col);
                    end
                    last_aec = c;
                    if (int'(dma_col) != c - 15) colerr++;
                end
                if (c == 55) rel55 = int'(cpu_rdy && ba && aec);
            end
            if (c == 62) break;
            @(negedge clk);
        end
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = 4'h0; cpu_rd = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        check("R3 ba-low cycles", ba_n, v.ba_n);
        check("R7 stalled cycles", st, v.stall);
        check("R5 fetch count", fc, v.fetch);
        check("R5 first column", col0, v.col0);
        check("R5 column tracks cycle", colerr, 0);
        check("R6 bus and ready back at 55", rel55, 1);
        if (v.ba_n > 0) check("R3 ba held to 54", last_ba, 54);
        if (v.fetch > 0) begin
            check("R4 aec three after ba", first_aec - first_ba, 3);
            check("R4 aec held to 54", last_aec, 54);
        end
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin : main
        int ln;
        repeat (4) @(negedge clk);
        #1;
        check("R9 cycle in reset", int'(raster_cycle), 0);
        check("R9 line in reset", int'(raster_line), 0);
        check("R9 bus lines in reset", int'({ba, aec, cpu_rdy, dma_fetch}), 4'b1110);
        rst = 1'b0;
        do @(negedge clk); while (int'(raster_cycle) != 62);
        ln = int'(raster_line);
        @(negedge clk);
        check("R1 cycle wraps", int'(raster_cycle), 0);
        check("R1 line advances", int'(raster_line), ln + 1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        do @(negedge clk);
        while (!(int'(raster_line) == 311 && int'(raster_cycle) == 62));
        @(negedge clk);
        check("R1 frame wraps line", int'(raster_line), 0);
        check("R1 frame wraps cycle", int'(raster_cycle), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule